// File: doc/BRIEF.md
# Inactivity-Driven Power Mode Controller

This block decides how often an optical motion sensor wakes up to take a motion-detect frame. It counts ticks of a free-running time base since motion was last seen. As the idle time grows, it moves from the run state through three rest levels, each deeper than the one before. Every level has its own polling period. The block emits a one-clock frame strobe at that period and publishes the live level as a 2-bit code.

A host register path can pin the controller to a chosen level, or hand control back to the automatic sequence. Either change takes effect only after a settling interval. A separate write puts the block into power-down. In power-down the block stops all frame activity and ignores every input except reset. It leaves power-down only through the synchronous reset input or a write of the key value to the reset port. Both paths perform a full reset. All delays and periods are parameters counted in ticks, so a simulation can use short values.

Top module: `rest_mode_ctrl`

## Requirements
- R1: After reset, `mode_o` is 2'b00 (run), `frame_o` is 0 and `pdn_o` is 0.
- R2: With automatic control and no motion, `mode_o` follows the number of ticks n since the last motion. The code is 2'b00 for n < IDLE_TO_R1, 2'b01 for IDLE_TO_R1 <= n < IDLE_TO_R2, 2'b10 for IDLE_TO_R2 <= n < IDLE_TO_R3, and 2'b11 from IDLE_TO_R3 on. The count saturates there.
- R3: Motion under automatic control returns `mode_o` to 2'b00 on the next clock and restarts the idle count from zero.
- R4: `frame_o` pulses for one clock after a tick. The pulses repeat every RUN_TICKS, R1_TICKS, R2_TICKS or R3_TICKS ticks, according to `mode_o` = 00, 01, 10 or 11.
- R5: A force write with a nonzero `force_sel_i` leaves `mode_o` unchanged for SETTLE_TICKS-1 ticks. `mode_o` takes the selected code one clock after the SETTLE_TICKS-th tick. From then on, motion does not change it.
- R6: A force write with `force_sel_i` = 2'b00 holds the forced level for SETTLE_TICKS-1 ticks, then returns to 2'b00 with the idle count cleared. Automatic downshifting resumes from there.
- R7: A `pdn_wr_i` pulse raises `pdn_o` on the next clock. While `pdn_o` is high, no frame strobe appears, `mode_o` holds its value, and motion and force writes have no effect.
- R8: A `reset_wr_i` pulse with `reset_data_i` = 8'h5A performs a full reset, as in R1, even in power-down. Any other data value is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-clock time-base pulse |
| motion_i | input | 1 | Motion reported in this cycle |
| force_wr_i | input | 1 | Host write strobe for the forced level |
| force_sel_i | input | 2 | Forced level: 00 automatic, 01/10/11 rest levels 1/2/3 |
| pdn_wr_i | input | 1 | Host write strobe that enters power-down |
| reset_wr_i | input | 1 | Host write strobe to the reset register |
| reset_data_i | input | 8 | Data of that write; 8'h5A is the reset key |
| mode_o | output | 2 | Live level: 00 run, 01/10/11 rest levels 1/2/3 |
| frame_o | output | 1 | One-clock frame-trigger strobe |
| pdn_o | output | 1 | Power-down state |

## Verification
The automatic sequence is exercised in two ways. Long directed idle runs check each threshold one tick before and at the crossing, which separates an off-by-one compare from a correct one. Random runs of idle gaps with motion between them are compared against a model of idle time, which shows that motion restarts the count and does not merely lift the level. Frame counts over windows that span whole periods in each forced level show that each level's period is selected correctly. Directed force, release, power-down and reset-key sequences test the settling delay, the blocking of motion and writes, and the rejection of a wrong key.

// File: rtl/rmc_pkg.sv
package rmc_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'b00,
    MODE_REST1 = 2'b01,
    MODE_REST2 = 2'b10,
    MODE_REST3 = 2'b11
  } mode_e;

  localparam logic [7:0] SOFT_RESET_KEY = 8'h5A;

endpackage

// File: rtl/rmc_idle_timer.sv
module rmc_idle_timer
  import rmc_pkg::*;
#(
  parameter int IDLE_TO_R1 = 900,
  parameter int IDLE_TO_R2 = 7000,
  parameter int IDLE_TO_R3 = 410000
) (
  input  logic  clk,
  input  logic  srst,
  input  logic  tick_en,
  input  logic  clr,
  output mode_e level_o
);

  localparam int W = $clog2(IDLE_TO_R3 + 1);

  logic [W-1:0] idle_q;

  // Saturating count of ticks since motion was last accepted.
  always_ff @(posedge clk) begin
    if (srst || clr) begin
      idle_q <= '0;
    end else if (tick_en && (idle_q < W'(IDLE_TO_R3))) begin
      idle_q <= idle_q + 1'b1;
    end
  end

  always_comb begin
    if (idle_q >= W'(IDLE_TO_R3))      level_o = MODE_REST3;
    else if (idle_q >= W'(IDLE_TO_R2)) level_o = MODE_REST2;
    else if (idle_q >= W'(IDLE_TO_R1)) level_o = MODE_REST1;
    else                               level_o = MODE_RUN;
  end

endmodule

// File: rtl/rmc_force_seq.sv
module rmc_force_seq
  import rmc_pkg::*;
#(
  parameter int SETTLE_TICKS = 1000
) (
  input  logic       clk,
  input  logic       srst,
  input  logic       tick_en,
  input  logic       wr_i,
  input  logic [1:0] sel_i,
  output logic       busy_o,
  output logic       held_o,
  output logic       done_o,
  output mode_e      target_o
);

  localparam int SW = $clog2(SETTLE_TICKS + 1);

  logic [SW-1:0] cnt_q;
  logic          busy_q;
  logic          held_q;
  logic          done_q;
  mode_e         target_q;

  always_ff @(posedge clk) begin
    if (srst) begin
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      held_q   <= 1'b0;
      done_q   <= 1'b0;
      target_q <= MODE_RUN;
    end else begin
      done_q <= 1'b0;
      if (wr_i) begin
        // A new write restarts the settling interval.
        busy_q   <= 1'b1;
        held_q   <= 1'b0;
        target_q <= mode_e'(sel_i);
        cnt_q    <= '0;
      end else if (busy_q && tick_en) begin
        if (cnt_q == SW'(SETTLE_TICKS - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          held_q <= (target_q != MODE_RUN);
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy_o   = busy_q;
  assign held_o   = held_q;
  assign done_o   = done_q;
  assign target_o = target_q;

endmodule

// File: rtl/rmc_frame_gen.sv
module rmc_frame_gen
  import rmc_pkg::*;
#(
  parameter int RUN_TICKS = 1,
  parameter int R1_TICKS  = 14,
  parameter int R2_TICKS  = 68,
  parameter int R3_TICKS  = 340
) (
  input  logic  clk,
  input  logic  srst,
  input  logic  tick_en,
  input  mode_e mode_i,
  output logic  frame_o
);

  localparam int PERIODS [4] = '{RUN_TICKS, R1_TICKS, R2_TICKS, R3_TICKS};
  localparam int MAXP = (RUN_TICKS > R1_TICKS ? RUN_TICKS : R1_TICKS) >
                        (R2_TICKS > R3_TICKS ? R2_TICKS : R3_TICKS) ?
                        (RUN_TICKS > R1_TICKS ? RUN_TICKS : R1_TICKS) :
                        (R2_TICKS > R3_TICKS ? R2_TICKS : R3_TICKS);
  localparam int PW = $clog2(MAXP + 1);

  logic [PW-1:0] last_tab [4];

  // Terminal phase value of each level's polling period.
  for (genvar g = 0; g < 4; g++) begin : g_period
    assign last_tab[g] = PW'(PERIODS[g] - 1);
  end

  logic [PW-1:0] phase_q;
  mode_e         seen_q;
  logic          frame_q;

  always_ff @(posedge clk) begin
    if (srst) begin
      phase_q <= '0;
      seen_q  <= MODE_RUN;
      frame_q <= 1'b0;
    end else begin
      frame_q <= 1'b0;
      if (mode_i != seen_q) begin
        seen_q  <= mode_i;
        phase_q <= '0;
      end else if (tick_en) begin
        if (phase_q >= last_tab[mode_i]) begin
          phase_q <= '0;
          frame_q <= 1'b1;
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end
    end
  end

  assign frame_o = frame_q;

endmodule

// File: rtl/rest_mode_ctrl.sv
module rest_mode_ctrl
  import rmc_pkg::*;
#(
  parameter int IDLE_TO_R1   = 900,
  parameter int IDLE_TO_R2   = 7000,
  parameter int IDLE_TO_R3   = 410000,
  parameter int RUN_TICKS    = 1,
  parameter int R1_TICKS     = 14,
  parameter int R2_TICKS     = 68,
  parameter int R3_TICKS     = 340,
  parameter int SETTLE_TICKS = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic       motion_i,
  input  logic       force_wr_i,
  input  logic [1:0] force_sel_i,
  input  logic       pdn_wr_i,
  input  logic       reset_wr_i,
  input  logic [7:0] reset_data_i,
  output logic [1:0] mode_o,
  output logic       frame_o,
  output logic       pdn_o
);

  logic  soft_rst;
  logic  srst;
  logic  pdn_q;
  logic  tick_en;
  logic  motion_ok;
  logic  idle_clr;
  logic  force_wr_ok;
  logic  force_busy;
  logic  force_held;
  logic  force_done;
  mode_e force_target;
  mode_e auto_level;
  mode_e mode_q;

  assign soft_rst    = reset_wr_i && (reset_data_i == SOFT_RESET_KEY);
  assign srst        = rst || soft_rst;
  assign tick_en     = tick_i && !pdn_q;
  assign motion_ok   = motion_i && !pdn_q && !force_busy && !force_held;
  assign idle_clr    = motion_ok || (force_done && (force_target == MODE_RUN));
  assign force_wr_ok = force_wr_i && !pdn_q;

  always_ff @(posedge clk) begin
    if (srst)          pdn_q <= 1'b0;
    else if (pdn_wr_i) pdn_q <= 1'b1;
  end

  rmc_idle_timer #(
    .IDLE_TO_R1(IDLE_TO_R1),
    .IDLE_TO_R2(IDLE_TO_R2),
    .IDLE_TO_R3(IDLE_TO_R3)
  ) u_idle (
    .clk     (clk),
    .srst    (srst),
    .tick_en (tick_en),
    .clr     (idle_clr),
    .level_o (auto_level)
  );

  rmc_force_seq #(
    .SETTLE_TICKS(SETTLE_TICKS)
  ) u_force (
    .clk      (clk),
    .srst     (srst),
    .tick_en  (tick_en),
    .wr_i     (force_wr_ok),
    .sel_i    (force_sel_i),
    .busy_o   (force_busy),
    .held_o   (force_held),
    .done_o   (force_done),
    .target_o (force_target)
  );

  // Level register: reset, power-down hold, forced apply, forced hold, auto.
  always_ff @(posedge clk) begin
    if (srst) begin
      mode_q <= MODE_RUN;
    end else if (pdn_q) begin
      mode_q <= mode_q;
    end else if (force_done) begin
      mode_q <= force_target;
    end else if (force_busy || force_held) begin
      mode_q <= mode_q;
    end else if (motion_i) begin
      mode_q <= MODE_RUN;
    end else begin
      mode_q <= auto_level;
    end
  end

  rmc_frame_gen #(
    .RUN_TICKS(RUN_TICKS),
    .R1_TICKS (R1_TICKS),
    .R2_TICKS (R2_TICKS),
    .R3_TICKS (R3_TICKS)
  ) u_frame (
    .clk     (clk),
    .srst    (srst),
    .tick_en (tick_en),
    .mode_i  (mode_q),
    .frame_o (frame_o)
  );

  assign mode_o = mode_q;
  assign pdn_o  = pdn_q;

endmodule

// File: rtl/rest_mode_ctrl_chk.sv
module rest_mode_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick_i,
  input logic       motion_i,
  input logic [1:0] mode_o,
  input logic       frame_o,
  input logic       pdn_o,
  input logic       soft_rst,
  input logic       force_busy,
  input logic       force_held,
  input logic       force_done
);

  a_r8_soft_reset: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (mode_o == 2'b00) && !pdn_o && !frame_o);

  a_r4_frame_after_tick: assert property (@(posedge clk) disable iff (rst)
    frame_o |-> $past(tick_i));

  a_r7_no_frame_in_pdn: assert property (@(posedge clk) disable iff (rst)
    (pdn_o && $past(pdn_o)) |-> !frame_o);

  a_r7_mode_frozen: assert property (@(posedge clk) disable iff (rst)
    (pdn_o && $past(pdn_o)) |-> $stable(mode_o));

  a_r3_motion_wakes: assert property (@(posedge clk) disable iff (rst)
    (motion_i && !pdn_o && !force_busy && !force_held && !soft_rst)
      |=> (mode_o == 2'b00));

  a_r5_forced_steady: assert property (@(posedge clk) disable iff (rst)
    (force_held && $past(force_held) && !$past(force_done)) |-> $stable(mode_o));

endmodule

bind rest_mode_ctrl rest_mode_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick_i     (tick_i),
  .motion_i   (motion_i),
  .mode_o     (mode_o),
  .frame_o    (frame_o),
  .pdn_o      (pdn_o),
  .soft_rst   (soft_rst),
  .force_busy (force_busy),
  .force_held (force_held),
  .force_done (force_done)
);

// File: tb/tb_rest_mode_ctrl.sv
module tb_rest_mode_ctrl;

  localparam int DS1 = 10;
  localparam int DS2 = 20;
  localparam int DS3 = 40;
  localparam int PRUN = 2;
  localparam int PR1 = 3;
  localparam int PR2 = 5;
  localparam int PR3 = 7;
  localparam int SETTLE = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0;
  logic       motion_i = 1'b0;
  logic       force_wr_i = 1'b0;
  logic [1:0] force_sel_i = 2'b00;
  logic       pdn_wr_i = 1'b0;
  logic       reset_wr_i = 1'b0;
  logic [7:0] reset_data_i = 8'h00;
  logic [1:0] mode_o;
  logic       frame_o;
  logic       pdn_o;

  int checks = 0;
  int errors = 0;
  int n_idle = 0;
  int frames = 0;
  int doubles = 0;
  bit prev_frame = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  rest_mode_ctrl #(
    .IDLE_TO_R1(DS1), .IDLE_TO_R2(DS2), .IDLE_TO_R3(DS3),
    .RUN_TICKS(PRUN), .R1_TICKS(PR1), .R2_TICKS(PR2), .R3_TICKS(PR3),
    .SETTLE_TICKS(SETTLE)
  ) dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .motion_i(motion_i),
    .force_wr_i(force_wr_i), .force_sel_i(force_sel_i), .pdn_wr_i(pdn_wr_i),
    .reset_wr_i(reset_wr_i), .reset_data_i(reset_data_i),
    .mode_o(mode_o), .frame_o(frame_o), .pdn_o(pdn_o)
  );

  function automatic int exp_level(int n);
    if (n >= DS3) return 3;
    if (n >= DS2) return 2;
    if (n >= DS1) return 1;
    return 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic sample_frame();
    if (frame_o) begin
      frames++;
      if (prev_frame) doubles++;
    end
    prev_frame = frame_o;
  endtask

  // One tick slot of four clocks; the idle model counts as the block should.
  task automatic step(bit mot, bit auto_ctl);
    @(negedge clk);
    sample_frame();
    tick_i   = 1'b1;
    motion_i = mot;
    @(negedge clk);
    tick_i   = 1'b0;
    motion_i = 1'b0;
    sample_frame();
    repeat (2) begin
      @(negedge clk);
      sample_frame();
    end
    if (auto_ctl) begin
      if (mot) n_idle = 0;
      else if (n_idle < DS3) n_idle++;
    end
  endtask

  task automatic idle_steps(int k, bit auto_ctl);
    for (int i = 0; i < k; i++) step(1'b0, auto_ctl);
  endtask

  task automatic force_write(logic [1:0] s);
    @(negedge clk);
    force_wr_i  = 1'b1;
    force_sel_i = s;
    @(negedge clk);
    force_wr_i  = 1'b0;
  endtask

  task automatic reset_write(logic [7:0] d);
    @(negedge clk);
    reset_wr_i   = 1'b1;
    reset_data_i = d;
    @(negedge clk);
    reset_wr_i   = 1'b0;
    reset_data_i = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 mode", mode_o, 0);
    check("R1 frame", frame_o, 0);
    check("R1 pdn", pdn_o, 0);

    // R4 run period with continuous motion
    frames = 0;
    for (int i = 0; i < 10; i++) step(1'b1, 1'b1);
    check("R4 run frames", frames, 10 / PRUN);

    // R2 thresholds, one tick before and at each crossing
    idle_steps(DS1 - 1, 1'b1);
    check("R2 before rest1", mode_o, 0);
    idle_steps(1, 1'b1);
    check("R2 at rest1", mode_o, 1);
    idle_steps(DS2 - DS1 - 1, 1'b1);
    check("R2 before rest2", mode_o, 1);
    idle_steps(1, 1'b1);
    check("R2 at rest2", mode_o, 2);
    idle_steps(DS3 - DS2 - 1, 1'b1);
    check("R2 before rest3", mode_o, 2);
    idle_steps(1, 1'b1);
    check("R2 at rest3", mode_o, 3);
    idle_steps(5, 1'b1);
    check("R2 saturate rest3", mode_o, 3);

    // R3 wake and timer restart
    step(1'b1, 1'b1);
    check("R3 wake", mode_o, 0);
    idle_steps(DS1 - 1, 1'b1);
    check("R3 restart before", mode_o, 0);
    idle_steps(1, 1'b1);
    check("R3 restart at rest1", mode_o, 1);

    // R5 force rest2
    force_write(2'b10);
    idle_steps(SETTLE - 1, 1'b0);
    check("R5 settling hold", mode_o, 1);
    idle_steps(1, 1'b0);
    check("R5 forced rest2", mode_o, 2);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
    check("R5 motion ignored", mode_o, 2);
    frames = 0;
    idle_steps(3 * PR2, 1'b0);
    check("R4 rest2 frames", frames, 3);

    force_write(2'b01);
    idle_steps(SETTLE, 1'b0);
    check("R5 forced rest1", mode_o, 1);
    frames = 0;
    idle_steps(3 * PR1, 1'b0);
    check("R4 rest1 frames", frames, 3);

    force_write(2'b11);
    idle_steps(SETTLE, 1'b0);
    check("R5 forced rest3", mode_o, 3);
    frames = 0;
    idle_steps(2 * PR3, 1'b0);
    check("R4 rest3 frames", frames, 2);

    // R6 release
    force_write(2'b00);
    idle_steps(SETTLE - 1, 1'b0);
    check("R6 release hold", mode_o, 3);
    idle_steps(1, 1'b0);
    check("R6 released run", mode_o, 0);
    n_idle = 0;
    idle_steps(DS1 - 1, 1'b1);
    check("R6 auto resumes before", mode_o, 0);
    idle_steps(1, 1'b1);
    check("R6 auto resumes rest1", mode_o, 1);

    // R2 R3 random idle gaps against the idle model
    for (int b = 0; b < 40; b++) begin
      int gap;
      gap = $urandom_range(0, 50);
      for (int i = 0; i < gap; i++) begin
        step(1'b0, 1'b1);
        check("R2 random level", mode_o, exp_level(n_idle));
      end
      step(1'b1, 1'b1);
      check("R3 random wake", mode_o, 0);
    end
    check("R4 single-clock strobe", doubles, 0);

    // R7 power-down
    idle_steps(12, 1'b1);
    check("R7 pre level", mode_o, 1);
    @(negedge clk);
    pdn_wr_i = 1'b1;
    @(negedge clk);
    pdn_wr_i = 1'b0;
    check("R7 pdn high", pdn_o, 1);
    frames = 0;
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0);
    force_write(2'b11);
    idle_steps(SETTLE + 2, 1'b0);
    check("R7 no frames", frames, 0);
    check("R7 mode held", mode_o, 1);

    // R8 reset key
    reset_write(8'h5B);
    check("R8 wrong key pdn", pdn_o, 1);
    check("R8 wrong key mode", mode_o, 1);
    reset_write(8'h5A);
    check("R8 key pdn cleared", pdn_o, 0);
    check("R8 key mode run", mode_o, 0);
    n_idle = 0;
    idle_steps(DS1 - 1, 1'b1);
    check("R8 fresh timer before", mode_o, 0);
    idle_steps(1, 1'b1);
    check("R8 fresh timer rest1", mode_o, 1);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule